// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets a host run Clause 22 management cycles on an external PHY through five 32-bit registers. Software writes the PHY and register numbers into a packed address register. For a write cycle it also loads the write-data register. It then sets one request bit in the control register. While the frame is on the wire, software polls a busy flag. Read results come back in a read-data register. The block generates MDC from the system clock with a parameterised divider and drives MDIO through a separate output and output-enable pair. The pad's input is returned on a plain input pin.

The register port is a single-cycle select/write-enable port. A write is accepted in the cycle it is presented and the port never stalls. A read returns combinationally from the register index, so there is no back-pressure to handle. A request presented while a frame is running has no effect. Software must wait for busy to drop before it raises another request.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, MDC is low, the MDIO output enable is low, and every register index reads zero.
- R2: The register indices are fixed. Index 0 is control, with bit 3 as the read request and bit 2 as the write request. Index 1 is the address, with the PHY number in bits 12:8 and the register number in bits 4:0. Index 2 is write data in bits 15:0. Index 3 is status, with bit 0 as busy. Index 4 is read data in bits 15:0. Unused bits and indices 5 to 7 read zero, and writes to indices 3 and 4 are ignored.
- R3: A control write with bit 3 or bit 2 set, made while idle, starts a frame and raises busy at that clock edge. If both bits are set, a read frame is run and only bit 3 reads back as set.
- R4: A control write made while busy leaves the running frame, the request bits and the number of MDC cycles unchanged.
- R5: The request bit that started a frame stays set while busy and clears at the edge where busy falls.
- R6: MDC has a half period of MDC_HALF_DIV system clocks. A frame lasts exactly 64 MDC periods, and busy is high for 128*MDC_HALF_DIV clocks.
- R7: The bits driven at successive rising MDC edges are as follows: 32 ones, then 0,1, then the opcode (1,0 for a read, 0,1 for a write), then the 5-bit PHY number and the 5-bit register number, both MSB first. A write frame continues with 1,0 and the 16 write-data bits, MSB first.
- R8: In a read frame, MDIO is driven for the first 46 bit times and released for the last 18 (turnaround and data).
- R9: In a read frame, the master samples MDIO at the rising MDC edge of each of the last 16 bit times, MSB first. The resulting value appears in the read-data register when busy falls, and it does not change at any other time.
- R10: A write frame drives MDIO for all 64 bit times and leaves the read-data register unchanged.
- R11: Between frames, MDC and the MDIO output enable stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Register access strobe |
| host_we | input | 1 | Write enable, qualified by host_sel |
| host_idx | input | 3 | Register index |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_idx, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, high while driving |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
A wrong bit counter or shift register shows up as a wrong bit at a specific rising MDC edge. It can also show as a busy window that is not exactly 128*MDC_HALF_DIV clocks, so it is visible within one frame. A stuck request bit or a missed start shows within a clock of the control write: the status and control readback disagree with busy, or MDC keeps toggling after busy falls. A mistimed capture shifts the read-data value by one bit. This is visible as soon as busy falls, because each PHY pattern is distinct for every address.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PHY_AW     = 5;
  localparam int REG_AW     = 5;
  localparam int DATA_W     = 16;
  localparam int BUS_W      = 32;
  localparam int IDX_W      = 3;
  localparam int PRE_BITS   = 32;
  localparam int TA_BITS    = 2;
  localparam int HDR_BITS   = PRE_BITS + 2 + 2 + PHY_AW + REG_AW;
  localparam int FRAME_BITS = HDR_BITS + TA_BITS + DATA_W;
  localparam int RD_FIRST   = HDR_BITS + TA_BITS;
  localparam int BIT_IDX_W  = $clog2(FRAME_BITS) + 1;

  localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_ADDR  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_WDATA = 3'd2;
  localparam logic [IDX_W-1:0] IDX_STAT  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_RDATA = 3'd4;

  localparam int CTRL_RD_BIT   = 3;
  localparam int CTRL_WR_BIT   = 2;
  localparam int ADDR_PHY_LSB  = 8;
  localparam int STAT_BUSY_BIT = 0;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } mdio_op_e;

  typedef struct packed {
    mdio_op_e              op;
    logic [PHY_AW-1:0]     phy;
    logic [REG_AW-1:0]     regad;
    logic [DATA_W-1:0]     wdata;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c);
    logic [1:0] opc;
    opc = (c.op == OP_READ) ? 2'b10 : 2'b01;
    return {{PRE_BITS{1'b1}}, 2'b01, opc, c.phy, c.regad, 2'b10, c.wdata};
  endfunction
endpackage

// File: rtl/mdio_mgmt_mdc_div.sv
module mdio_mgmt_mdc_div #(
  parameter int HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (HALF_DIV <= 1) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt;

      assign tick = run && (cnt == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (!run || tick) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                start,
  input  mdio_cmd_t           cmd,
  input  logic                mdio_i,
  output logic                busy,
  output logic                finish,
  output logic                is_read,
  output logic [DATA_W-1:0]   rd_value,
  output logic                mdc,
  output logic                mdio_o,
  output logic                mdio_oe
);
  localparam logic [BIT_IDX_W-1:0] LAST_IDX = BIT_IDX_W'(FRAME_BITS - 1);
  localparam logic [BIT_IDX_W-1:0] HDR_END  = BIT_IDX_W'(HDR_BITS);
  localparam logic [BIT_IDX_W-1:0] CAP_FROM = BIT_IDX_W'(RD_FIRST);

  logic [FRAME_BITS-1:0] shreg;
  logic [BIT_IDX_W-1:0]  bit_idx;
  logic [BIT_IDX_W-1:0]  next_idx;
  logic [DATA_W-1:0]     cap_sh;
  logic [FRAME_BITS-1:0] new_frame;

  assign new_frame = build_frame(cmd);
  assign next_idx  = bit_idx + 1'b1;
  assign finish    = busy && tick && mdc && (bit_idx == LAST_IDX);
  assign rd_value  = cap_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      is_read <= 1'b0;
      shreg   <= '0;
      bit_idx <= '0;
      cap_sh  <= '0;
      mdc     <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        is_read <= (cmd.op == OP_READ);
        shreg   <= new_frame;
        bit_idx <= '0;
        mdc     <= 1'b0;
        mdio_o  <= new_frame[FRAME_BITS-1];
        mdio_oe <= 1'b1;
      end
    end else if (tick) begin
      if (!mdc) begin
        mdc <= 1'b1;
        if (is_read && (bit_idx >= CAP_FROM)) begin
          cap_sh <= {cap_sh[DATA_W-2:0], mdio_i};
        end
      end else begin
        mdc <= 1'b0;
        if (bit_idx == LAST_IDX) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
        end else begin
          bit_idx <= next_idx;
          shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
          mdio_o  <= shreg[FRAME_BITS-2];
          mdio_oe <= !(is_read && (next_idx >= HDR_END));
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_we,
  input  logic [IDX_W-1:0]   host_idx,
  input  logic [BUS_W-1:0]   host_wdata,
  output logic [BUS_W-1:0]   host_rdata,
  input  logic               eng_busy,
  input  logic               eng_finish,
  input  logic               eng_is_read,
  input  logic [DATA_W-1:0]  eng_rd_value,
  output logic               start,
  output mdio_cmd_t          cmd,
  output logic               req_rd,
  output logic               req_wr,
  output logic [DATA_W-1:0]  rdata_q
);
  logic [PHY_AW-1:0] phy_q;
  logic [REG_AW-1:0] reg_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_any;
  logic              want_rd;
  logic              want_wr;

  assign wr_any  = host_sel && host_we;
  assign want_rd = host_wdata[CTRL_RD_BIT];
  assign want_wr = host_wdata[CTRL_WR_BIT];
  assign start   = wr_any && (host_idx == IDX_CTRL) && !eng_busy && (want_rd || want_wr);

  always_comb begin
    cmd.op    = want_rd ? OP_READ : OP_WRITE;
    cmd.phy   = phy_q;
    cmd.regad = reg_q;
    cmd.wdata = wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q   <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
      req_rd  <= 1'b0;
      req_wr  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_any && host_idx == IDX_ADDR) begin
        phy_q <= host_wdata[ADDR_PHY_LSB +: PHY_AW];
        reg_q <= host_wdata[REG_AW-1:0];
      end
      if (wr_any && host_idx == IDX_WDATA) begin
        wdata_q <= host_wdata[DATA_W-1:0];
      end
      if (start) begin
        req_rd <= want_rd;
        req_wr <= !want_rd;
      end else if (eng_finish) begin
        req_rd <= 1'b0;
        req_wr <= 1'b0;
      end
      if (eng_finish && eng_is_read) begin
        rdata_q <= eng_rd_value;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_idx)
      IDX_CTRL: begin
        host_rdata[CTRL_RD_BIT] = req_rd;
        host_rdata[CTRL_WR_BIT] = req_wr;
      end
      IDX_ADDR: begin
        host_rdata[ADDR_PHY_LSB +: PHY_AW] = phy_q;
        host_rdata[REG_AW-1:0]             = reg_q;
      end
      IDX_WDATA: host_rdata[DATA_W-1:0]   = wdata_q;
      IDX_STAT:  host_rdata[STAT_BUSY_BIT] = eng_busy;
      IDX_RDATA: host_rdata[DATA_W-1:0]   = rdata_q;
      default:   host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF_DIV = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_we,
  input  logic [2:0]  host_idx,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              eng_busy;
  logic              eng_finish;
  logic              eng_is_read;
  logic [DATA_W-1:0] eng_rd_value;
  logic              start;
  mdio_cmd_t         cmd;
  logic              req_rd;
  logic              req_wr;
  logic [DATA_W-1:0] rdata_q;
  logic              tick;

  mdio_mgmt_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_sel     (host_sel),
    .host_we      (host_we),
    .host_idx     (host_idx),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .eng_busy     (eng_busy),
    .eng_finish   (eng_finish),
    .eng_is_read  (eng_is_read),
    .eng_rd_value (eng_rd_value),
    .start        (start),
    .cmd          (cmd),
    .req_rd       (req_rd),
    .req_wr       (req_wr),
    .rdata_q      (rdata_q)
  );

  mdio_mgmt_mdc_div #(.HALF_DIV(MDC_HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (eng_busy),
    .tick  (tick)
  );

  mdio_mgmt_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .start    (start),
    .cmd      (cmd),
    .mdio_i   (mdio_i),
    .busy     (eng_busy),
    .finish   (eng_finish),
    .is_read  (eng_is_read),
    .rd_value (eng_rd_value),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        req_rd,
  input logic        req_wr,
  input logic [15:0] rdata
);
  // R5: request bits mirror the busy window
  assert_req_tracks_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd || req_wr) == busy);

  // R3: at most one request recorded
  assert_single_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_rd, req_wr}));

  // R11: idle pins
  assert_idle_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R9: read data only moves when a frame ends
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $fell(busy));

  // R7: a frame opens by driving a preamble one
  assert_frame_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mdio_oe && mdio_o && !mdc));
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (eng_busy),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .req_rd  (req_rd),
  .req_wr  (req_wr),
  .rdata   (rdata_q)
);

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;
  localparam int DIV = 2;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_idx = 3'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [63:0] cap_bit = '0;
  logic [63:0] cap_oe = '0;
  int rise_cnt = 0;
  int fall_cnt = 0;
  logic mdc_prev = 1'b0;
  logic [15:0] phy_word = '0;

  always #4 clk = ~clk;

  mdio_mgmt_master #(.MDC_HALF_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: drives its word in the last 16 bit times, pull-up otherwise
  assign mdio_i = (fall_cnt >= 48 && fall_cnt < 64) ? phy_word[63 - fall_cnt] : 1'b1;

  always @(negedge clk) begin
    if (mdc && !mdc_prev) begin
      if (rise_cnt < 64) begin
        cap_bit[63 - rise_cnt] = mdio_o;
        cap_oe[63 - rise_cnt]  = mdio_oe;
      end
      rise_cnt = rise_cnt + 1;
    end
    if (!mdc && mdc_prev) fall_cnt = fall_cnt + 1;
    mdc_prev = mdc;
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act %0d exp below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_idx = idx; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0; host_wdata = '0;
  endtask

  task automatic host_read(input logic [2:0] idx, output logic [31:0] d);
    host_idx = idx;
    #1;
    d = host_rdata;
  endtask

  task automatic clear_mon();
    @(posedge clk);
    #1;
    rise_cnt = 0; fall_cnt = 0; cap_bit = '0; cap_oe = '0;
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] w);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, w};
  endfunction

  task automatic wait_idle(output int bc);
    logic [31:0] s;
    bc = 0;
    host_read(3'd3, s);
    while (s[0] && bc < 20000) begin
      bc++;
      @(negedge clk);
      host_read(3'd3, s);
    end
  endtask

  // Runs one frame with a given control word and checks it
  task automatic run_frame(input logic [31:0] ctrl, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] w, input logic [15:0] pat);
    logic [31:0] v;
    logic [31:0] rd_before;
    logic [63:0] ef, mask;
    int bc;
    bit rd;
    rd = ctrl[3];
    host_read(3'd4, rd_before);
    host_write(3'd1, {19'd0, p, 3'd0, r});
    host_write(3'd2, {16'd0, w});
    phy_word = pat;
    clear_mon();
    host_write(3'd0, ctrl);
    host_read(3'd0, v);
    chk(v == (rd ? 32'h8 : 32'h4), "R3 R5 request bit while busy", v, rd ? 32'h8 : 32'h4);
    wait_idle(bc);
    chk(bc == 128 * DIV, "R6 busy length", bc, 128 * DIV);
    chk(rise_cnt == 64 && fall_cnt == 64, "R6 MDC cycles", rise_cnt, 64);
    ef = exp_frame(rd, p, r, w);
    mask = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
    chk(((cap_bit ^ ef) & mask) == 0, "R7 frame bits", cap_bit & mask, ef & mask);
    chk(cap_oe == mask, rd ? "R8 read drive window" : "R10 write drive window", cap_oe, mask);
    host_read(3'd4, v);
    if (rd) chk(v == {16'd0, pat}, "R9 read data", v, {16'd0, pat});
    else    chk(v == rd_before, "R10 read data kept", v, rd_before);
    host_read(3'd0, v);
    chk(v == 0, "R5 request cleared", v, 0);
    chk(!mdc && !mdio_oe, "R11 idle pins", {mdc, mdio_oe}, 0);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] keep;
    int bc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!mdc && !mdio_oe, "R1 pins in reset", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      host_read(3'(i), v);
      chk(v == 0, "R1 register reset value", v, 0);
    end
    // R2 field placement and unused bits
    host_write(3'd1, 32'hFFFF_FFFF);
    host_read(3'd1, v);
    chk(v == 32'h0000_1F1F, "R2 address fields", v, 32'h1F1F);
    host_write(3'd2, 32'hFFFF_FFFF);
    host_read(3'd2, v);
    chk(v == 32'h0000_FFFF, "R2 write data width", v, 32'hFFFF);
    host_write(3'd3, 32'hFFFF_FFFF);
    host_write(3'd4, 32'hFFFF_FFFF);
    host_write(3'd6, 32'hFFFF_FFFF);
    host_read(3'd3, v);
    chk(v == 0 && !mdc, "R2 status write ignored", v, 0);
    host_read(3'd4, v);
    chk(v == 0, "R2 read data write ignored", v, 0);
    host_read(3'd6, v);
    chk(v == 0, "R2 unmapped index", v, 0);
    host_write(3'd0, 32'hFFFF_FFF3);
    host_read(3'd3, v);
    chk(v == 0, "R3 no request bit no start", v, 0);

    // Sweep every PHY address with read and write frames
    for (int p = 0; p < 32; p++) begin
      run_frame(32'h8, 5'(p), 5'(31 - p), 16'(p * 16'h0777),
                16'(p * 16'h0841) ^ 16'hA5C3);
      run_frame(32'h4, 5'(p), 5'(p), 16'(p * 16'h1111) ^ 16'h5A0F, 16'h0000);
    end

    // R3 both request bits: read wins
    run_frame(32'hC, 5'd9, 5'd22, 16'h1234, 16'h8001);

    // R4 request during a frame is ignored
    host_read(3'd4, keep);
    host_write(3'd1, {19'd0, 5'd3, 3'd0, 5'd17});
    host_write(3'd2, 32'h0000_C3C3);
    clear_mon();
    host_write(3'd0, 32'h4);
    repeat (40) @(negedge clk);
    host_write(3'd0, 32'h8);
    host_read(3'd0, v);
    chk(v == 32'h4, "R4 request bits unchanged", v, 32'h4);
    wait_idle(bc);
    chk(cap_bit[29:28] == 2'b01, "R4 opcode stays write", cap_bit[29:28], 2'b01);
    repeat (300) @(negedge clk);
    chk(rise_cnt == 64, "R4 no extra frame", rise_cnt, 64);
    host_read(3'd4, v);
    chk(v == keep, "R4 R10 read data kept", v, keep);
    chk(!mdc && !mdio_oe, "R11 idle after ignored request", {mdc, mdio_oe}, 0);

    done = 1'b1;
    finish_run();
  end
endmodule